// File: doc/BRIEF.md
# Output Short-Circuit Retry-and-Latch Controller

This block protects a pair of motor output bridges against shorts. It watches a short-circuit detect bit that has already been synchronised to the clock. A short only counts once it has been present for a set number of consecutive clocks. When a short counts, the controller turns the bridges off for a fixed cool-down time. It then turns them on again for one trial period.

If the short returns during that trial period, the controller locks the bridges off and raises a fault flag. Only a standby request can release that lock. If the trial period ends without a short, the controller goes back to normal operation and can make another off-and-retry attempt later.

All three time spans are parameters counted in clock cycles: the qualification time, the cool-down and the trial window. With a 100 MHz clock, a cool-down of about 256 µs is 25600 cycles. The standby input is active low. While it is low, the bridges are off, the fault flag clears and every internal counter is held at zero.

Top module: `short_guard`

## Requirements
- R1: After reset the controller is in normal operation. `fault` is 0 and `bridge_en` equals `standby_n`.
- R2: `bridge_en` goes to 0 after the clock edge that samples `short_det` high for the QUAL_CYCLES-th consecutive time, when this happens in normal operation.
- R3: If `short_det` is sampled low before the qualification count completes, the count restarts from zero. A fresh run of QUAL_CYCLES consecutive high samples is then needed.
- R4: After a qualified short, `bridge_en` stays 0 for exactly OFF_CYCLES clock cycles and then returns to 1. `short_det` is ignored during this time.
- R5: A short that qualifies during the trial window sets `bridge_en` to 0 and `fault` to 1 after the qualifying edge.
- R6: If no short qualifies within the RETRY_CYCLES cycles of the trial window, the controller returns to normal operation. A later short then causes a new off-and-retry sequence, not an immediate latch.
- R7: Once latched, `fault` stays 1 and `bridge_en` stays 0 for as long as `standby_n` is 1, whatever `short_det` does.
- R8: While `standby_n` is 0, `bridge_en` is 0 in the same cycle and `fault` is 0 after the next edge. `short_det` is not counted. When `standby_n` returns to 1, the controller is in normal operation with an empty qualification count.
- R9: When a short qualifies on the same edge that ends the trial window, the controller latches rather than returning to normal operation.
- R10: `fault` and `bridge_en` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_n | input | 1 | Standby request, active low; releases the latch |
| short_det | input | 1 | Synchronised short-circuit detect, active high |
| bridge_en | output | 1 | Output bridge enable |
| fault | output | 1 | Latched short-circuit fault flag |

## Verification
The bench interrupts a short one sample before it would qualify. A design that kept a cumulative count rather than a consecutive one would shut the bridges off early.

It counts the exact length of the off time and of the trial window, so an off-by-one in the timer shows as an output that turns on a cycle early or late. It also lets a short qualify on the final edge of the trial window. A design that gave the window expiry priority would fall back to normal operation instead of latching.

Finally, it holds the short high throughout a standby period. A qualifier that kept counting while in standby would shut the bridges off on the first cycle after release.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL   = 2'd0,
    ST_OFF_WAIT = 2'd1,
    ST_RETRY    = 2'd2,
    ST_LATCHED  = 2'd3
  } sg_state_e;

  // True when a counter holding 'cnt' completes 'target' events on this edge.
  function automatic logic count_reached(input int unsigned cnt,
                                         input int unsigned target);
    return (cnt + 1) >= target;
  endfunction

endpackage

// File: rtl/sg_qualifier.sv
module sg_qualifier #(
  parameter int unsigned QUAL_CYCLES = 8,
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic short_in,
  output logic hit
);
  import sg_pkg::*;

  logic [CW-1:0] run_cnt;

  assign hit = short_in && count_reached(32'(run_cnt), QUAL_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (clear || !short_in) run_cnt <= '0;
    else if (!hit)              run_cnt <= run_cnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_cnt) < QUAL_CYCLES); // R3

endmodule

// File: rtl/sg_timer.sv
module sg_timer #(
  parameter int unsigned OFF_CYCLES   = 25600,
  parameter int unsigned RETRY_CYCLES = 25600,
  localparam int unsigned MAXC = (OFF_CYCLES > RETRY_CYCLES) ? OFF_CYCLES : RETRY_CYCLES,
  localparam int unsigned TW   = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic sel_retry,
  output logic expire
);
  import sg_pkg::*;

  logic [TW-1:0] tick_cnt;
  int unsigned   limit;

  assign limit  = sel_retry ? RETRY_CYCLES : OFF_CYCLES;
  assign expire = run && count_reached(32'(tick_cnt), limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tick_cnt <= '0;
    else if (restart || !run)  tick_cnt <= '0;
    else                       tick_cnt <= tick_cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> 32'(tick_cnt) < limit); // R4

endmodule

// File: rtl/short_guard.sv
module short_guard #(
  parameter int unsigned QUAL_CYCLES  = 8,
  parameter int unsigned OFF_CYCLES   = 25600,
  parameter int unsigned RETRY_CYCLES = 25600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_n,
  input  logic short_det,
  output logic bridge_en,
  output logic fault
);
  import sg_pkg::*;

  sg_state_e state, nxt;

  logic qual_hit, qual_clear;
  logic tmr_run, tmr_restart, tmr_expire;
  logic monitoring;
  logic ev_detect, ev_latch, ev_release;

  assign monitoring = (state == ST_NORMAL) || (state == ST_RETRY);
  assign qual_clear = !standby_n || !monitoring;

  sg_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) i_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (qual_clear),
    .short_in (short_det),
    .hit      (qual_hit)
  );

  assign tmr_run     = standby_n && ((state == ST_OFF_WAIT) || (state == ST_RETRY));
  assign tmr_restart = (nxt != state);

  sg_timer #(.OFF_CYCLES(OFF_CYCLES), .RETRY_CYCLES(RETRY_CYCLES)) i_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tmr_run),
    .restart   (tmr_restart),
    .sel_retry (state == ST_RETRY),
    .expire    (tmr_expire)
  );

  // Named events for the assertions
  assign ev_detect  = standby_n && (state == ST_NORMAL) && qual_hit;
  assign ev_latch   = standby_n && (state == ST_RETRY)  && qual_hit;
  assign ev_release = !standby_n;

  always_comb begin
    nxt = state;
    if (!standby_n) nxt = ST_NORMAL;
    else begin
      unique case (state)
        ST_NORMAL:   if (qual_hit)   nxt = ST_OFF_WAIT;
        ST_OFF_WAIT: if (tmr_expire) nxt = ST_RETRY;
        ST_RETRY: begin
          if (qual_hit)        nxt = ST_LATCHED;  // wins over window expiry
          else if (tmr_expire) nxt = ST_NORMAL;
        end
        default:                     nxt = ST_LATCHED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_NORMAL;
    else        state <= nxt;
  end

  assign bridge_en = standby_n && monitoring;
  assign fault     = (state == ST_LATCHED);

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !bridge_en); // R10
  AST_DETECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_detect |=> !bridge_en); // R2
  AST_LATCH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |=> fault); // R5
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && standby_n) |=> fault); // R7
  AST_STANDBY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> !fault); // R8
  AST_RETRY_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RETRY && $past(state) != ST_RETRY) |-> $past(state) == ST_OFF_WAIT); // R4

endmodule

// File: tb/test_short_guard.sv
module test_short_guard;
  localparam int unsigned Q = 3;
  localparam int unsigned OFFC = 5;
  localparam int unsigned WIN = 6;

  logic clk = 1'b0;
  logic rst_n, standby_n, short_det;
  logic bridge_en, fault;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  short_guard #(.QUAL_CYCLES(Q), .OFF_CYCLES(OFFC), .RETRY_CYCLES(WIN)) i_short_guard (
    .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .short_det(short_det),
    .bridge_en(bridge_en), .fault(fault)
  );

  // One entry per clock: {standby_n, short_det, expected bridge_en, expected fault}
  localparam logic [3:0] VEC [0:32] = '{
    4'b1010,                                  // R1 idle
    4'b1110, 4'b1110,                         // R2 two samples high
    4'b1010,                                  // R3 glitch restarts count
    4'b1110, 4'b1110, 4'b1100,                // R2 third consecutive -> off
    4'b1100, 4'b1000, 4'b1000, 4'b1000,       // R4 off time, short ignored
    4'b1010,                                  // R4 retry begins
    4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1010,
    4'b1010,                                  // R6 window ends -> normal
    4'b1110, 4'b1110, 4'b1100,                // R6 new sequence, no latch
    4'b1100, 4'b1100, 4'b1100, 4'b1100,       // R4
    4'b1110,                                  // R4 retry again
    4'b1110, 4'b1110, 4'b1101,                // R5 short in retry -> latch
    4'b1001, 4'b1101,                         // R7 latch holds
    4'b0000,                                  // R8 standby releases
    4'b1010                                   // R8 back to normal
  };
  localparam int REQ [0:32] = '{1, 2,2, 3, 3,3,2, 4,4,4,4, 4, 6,6,6,6,6, 6, 6,6,6,
                                4,4,4,4, 4, 5,5,5, 7,7, 8, 8};

  task automatic step(input logic sb, input logic sh, input logic eb, input logic ef,
                      input string tag);
    @(negedge clk);
    standby_n = sb;
    short_det = sh;
    @(posedge clk);
    #2;
    n_chk++;
    if (bridge_en !== eb || fault !== ef) begin
      n_bad++;
      $display("FAIL %s: bridge_en=%b fault=%b expected bridge_en=%b fault=%b",
               tag, bridge_en, fault, eb, ef);
    end
  endtask

  task automatic check_now(input logic eb, input logic ef, input string tag);
    n_chk++;
    if (bridge_en !== eb || fault !== ef) begin
      n_bad++;
      $display("FAIL %s: bridge_en=%b fault=%b expected bridge_en=%b fault=%b",
               tag, bridge_en, fault, eb, ef);
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; standby_n = 1'b1; short_det = 1'b0;
    repeat (2) @(negedge clk);
    check_now(1'b1, 1'b0, "R1 reset, standby high");
    standby_n = 1'b0;
    #1;
    check_now(1'b0, 1'b0, "R1 reset, standby low");
    standby_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 33; i++)
      step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R%0d vec%0d", REQ[i], i));

    // R9: qualification completes on the last edge of the trial window
    step(1, 1, 1, 0, "R9 q1");
    step(1, 1, 1, 0, "R9 q2");
    step(1, 1, 0, 0, "R9 off");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, "R9 off wait");
    step(1, 0, 1, 0, "R9 retry start");
    for (int k = 0; k < 3; k++) step(1, 0, 1, 0, "R9 retry quiet");
    step(1, 1, 1, 0, "R9 short 1");
    step(1, 1, 1, 0, "R9 short 2");
    step(1, 1, 0, 1, "R9 latch on window end");
    check_now(1'b0, 1'b1, "R10 fault excludes bridge_en");

    // R8: short held through standby is not counted
    for (int k = 0; k < 5; k++) step(0, 1, 0, 0, "R8 standby with short");
    step(1, 1, 1, 0, "R8 release, count empty");
    step(1, 1, 1, 0, "R8 second sample");
    step(1, 1, 0, 0, "R2 third sample after release");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule